// File: doc/BRIEF.md
# Stability-Gated System Clock Selector

This block picks the system clock from three candidate sources: a fast internal RC oscillator, a fast external oscillator and a PLL. Each source supplies a ready flag, which the block synchronises into its own clock domain. Every source is also represented by a one-cycle enable pulse train on a single fast reference clock. The block passes one of these trains through to `sysclk_en`, and that output stands in for the glitch-free system clock. Software asks for a source with a 2-bit code. The block moves to that source only once the source reports stable. It also locks the PLL settings while the PLL runs, and it refuses to stop the internal RC while the RC drives the system clock, either directly or as the PLL's reference.

The handover works as follows. The block waits for the old source's enable to be low, then cuts the gate. It then waits for the new source's enable to be low before it opens the gate again, so that the first pulse seen downstream is whole. If the running source loses its ready flag, the block falls back to the internal RC and sets a sticky failure flag. There are no data streams here: every pin is a plain level or a one-cycle strobe, and none of them is handshaked.

Top module: `sysclk_selector`

## Requirements
- R1: After reset, `src_active` and `src_target` are 00 (internal RC). `clk_fail` and `pll_clk_ok` are 0, `hirc_on` is 1 and `pll_cfg` is all zeros.
- R2: Source codes are 00 internal RC, 01 external oscillator and 10 PLL. A request strobe carrying the reserved code 11 leaves `src_target` unchanged. Any other code is loaded into `src_target` on the next edge.
- R3: `src_active` changes to the requested source only after that source's ready flag has passed two synchronising flops and the source is usable. Until then the old source stays active and `switching` reads 1. The internal RC is usable only while `hirc_on` is 1, and the PLL is usable only while it is enabled.
- R4: `pll_clk_ok` is 1 only while the PLL is enabled and its synchronised ready flag is high. The PLL cannot become the active source otherwise.
- R5: A configuration write updates `pll_cfg` only while the PLL is disabled. Writes made while the PLL runs are dropped.
- R6: A stop request clears `hirc_on` unless the RC is the active or target source, or unless the PLL is active or target while `pll_cfg` bit 0 is 0 (bit 0 = 0 means the PLL takes its reference from the RC). A start request sets `hirc_on`.
- R7: `sysclk_en` is high only in cycles where the enable train of `src_active` is high.
- R8: Every rising edge of `sysclk_en` follows a cycle in which the active source's enable train was low, so no partial first pulse appears.
- R9: If a non-RC active source loses its synchronised ready, both `src_active` and `src_target` return to 00, `hirc_on` is forced to 1 and `clk_fail` sets. `clk_fail` stays set until reset.
- R10: Clearing `pll_en` does not stop the PLL while the PLL is the active or target source. It stops once neither holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Fast reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_tick | input | 3 | Per-source enable pulse trains (bit = source code) |
| src_rdy | input | 3 | Per-source raw ready flags (bit = source code) |
| req_we | input | 1 | Source request strobe |
| req_code | input | 2 | Requested source code |
| pll_en | input | 1 | PLL enable request |
| cfg_we | input | 1 | PLL configuration write strobe |
| cfg_wdata | input | CFG_W | PLL configuration write data, bit 0 picks the reference |
| hirc_stop | input | 1 | Request to stop the internal RC |
| hirc_start | input | 1 | Request to start the internal RC |
| src_target | output | 2 | Accepted requested source |
| src_active | output | 2 | Source actually driving the system clock |
| switching | output | 1 | Handover in progress |
| clk_fail | output | 1 | Sticky failure flag after a fallback |
| hirc_on | output | 1 | Internal RC running |
| pll_clk_ok | output | 1 | PLL enabled and stable |
| pll_cfg | output | CFG_W | Current PLL configuration |
| sysclk_en | output | 1 | Gated system clock enable |

## Verification
A corrupted handover state shows up within a few reference cycles. It appears either as `src_active` moving before the synchronised ready of the target, or as a `sysclk_en` pulse that does not line up with the active source's train. A lost request shows immediately on `src_target`. A broken lock on the PLL settings or on the RC shows on `pll_cfg` or `hirc_on` one edge after the offending strobe. A missed failure shows within three cycles of the ready drop, as `src_active` staying put or `clk_fail` staying low.

// File: rtl/sysclk_sel_pkg.sv
package sysclk_sel_pkg;
  localparam int unsigned NUM_SRC = 3;
  localparam logic [1:0] CODE_HIRC = 2'b00;
  localparam logic [1:0] CODE_HEXT = 2'b01;
  localparam logic [1:0] CODE_PLL  = 2'b10;
  localparam logic [1:0] CODE_RSVD = 2'b11;

  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_WAIT = 2'd1,
    ST_CUT  = 2'd2,
    ST_HOLD = 2'd3
  } sw_state_e;
endpackage

// File: rtl/rdy_sync.sv
module rdy_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[STAGES-2:0], d};
  end

  assign q = sh[STAGES-1];
endmodule

// File: rtl/sysclk_switch_fsm.sv
module sysclk_switch_fsm
  import sysclk_sel_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] rdy_ok,
  input  logic [NUM_SRC-1:0] tick,
  input  logic               req_we,
  input  logic [1:0]         req_code,
  output logic [1:0]         active,
  output logic [1:0]         target,
  output logic               switching,
  output logic               fail,
  output logic               fallback,
  output logic               sysclk_en
);
  sw_state_e  state;
  logic       gate_on;
  logic       req_ok;
  logic [3:0] rdy4;
  logic [3:0] tick4;

  assign rdy4     = {1'b0, rdy_ok};
  assign tick4    = {1'b0, tick};
  assign req_ok   = req_we && (req_code != CODE_RSVD);
  assign fallback = (active != CODE_HIRC) && !rdy4[active];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_RUN;
      active  <= CODE_HIRC;
      target  <= CODE_HIRC;
      gate_on <= 1'b1;
      fail    <= 1'b0;
    end else if (fallback) begin
      active  <= CODE_HIRC;
      target  <= CODE_HIRC;
      gate_on <= 1'b0;
      fail    <= 1'b1;
      state   <= ST_HOLD;
    end else begin
      if (req_ok) target <= req_code;
      case (state)
        ST_RUN: begin
          if (target != active) state <= ST_WAIT;
        end
        ST_WAIT: begin
          if (target == active)  state <= ST_RUN;
          else if (rdy4[target]) state <= ST_CUT;
        end
        ST_CUT: begin
          if (!rdy4[target]) begin
            state <= ST_WAIT;
          end else if (!tick4[active]) begin
            gate_on <= 1'b0;
            active  <= target;
            state   <= ST_HOLD;
          end
        end
        default: begin
          if (!tick4[active]) begin
            gate_on <= 1'b1;
            state   <= ST_RUN;
          end
        end
      endcase
    end
  end

  assign switching = (state != ST_RUN);
  assign sysclk_en = gate_on && tick4[active];

  // R3: a normal handover lands only on a source that was usable the cycle before
  a_r3_switch_needs_ready: assert property (@(posedge clk) disable iff (!rst_n)
    ((active != $past(active)) && !$past(fallback)) |-> (|($past(rdy4) & (4'b0001 << active))))
    else $error("a_r3_switch_needs_ready");

  // R2: the reserved code never reaches the target register
  a_r2_reserved_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(req_we) && ($past(req_code) == CODE_RSVD) && !$past(fallback)) |-> (target == $past(target)))
    else $error("a_r2_reserved_ignored");

  // R8: the gated enable only rises after a low cycle of the active train
  a_r8_whole_first_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sysclk_en) |-> !(|($past(tick4) & (4'b0001 << active))))
    else $error("a_r8_whole_first_pulse");

  // R9: failure flag is sticky and coincides with the RC being active
  a_r9_fail_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    $past(fail) |-> fail)
    else $error("a_r9_fail_sticky");

  a_r9_fallback_to_rc: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fail) |-> (active == CODE_HIRC && target == CODE_HIRC))
    else $error("a_r9_fallback_to_rc");
endmodule

// File: rtl/pll_rc_guard.sv
module pll_rc_guard
  import sysclk_sel_pkg::*;
#(
  parameter int unsigned CFG_W   = 8,
  parameter int unsigned REF_BIT = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pll_en,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic             hirc_stop,
  input  logic             hirc_start,
  input  logic [1:0]       active,
  input  logic [1:0]       target,
  input  logic             fallback,
  output logic             pll_on,
  output logic [CFG_W-1:0] pll_cfg,
  output logic             hirc_on
);
  logic pll_in_use;
  logic rc_in_use;

  assign pll_in_use = (active == CODE_PLL) || (target == CODE_PLL);
  assign rc_in_use  = (active == CODE_HIRC) || (target == CODE_HIRC) ||
                      (pll_in_use && !pll_cfg[REF_BIT]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pll_on  <= 1'b0;
      pll_cfg <= '0;
      hirc_on <= 1'b1;
    end else begin
      pll_on <= pll_en || (pll_on && pll_in_use);
      if (cfg_we && !pll_on) pll_cfg <= cfg_wdata;
      if (fallback || hirc_start) hirc_on <= 1'b1;
      else if (hirc_stop && !rc_in_use) hirc_on <= 1'b0;
    end
  end

  // R5: settings frozen while the PLL was running
  a_r5_cfg_locked: assert property (@(posedge clk) disable iff (!rst_n)
    $past(pll_on) |-> $stable(pll_cfg))
    else $error("a_r5_cfg_locked");

  // R6: the RC keeps running while it drives the clock directly or via the PLL
  a_r6_rc_kept: assert property (@(posedge clk) disable iff (!rst_n)
    ((active == CODE_HIRC) || ((active == CODE_PLL) && !pll_cfg[REF_BIT])) |-> hirc_on)
    else $error("a_r6_rc_kept");

  // R10: an active PLL stays enabled
  a_r10_pll_held: assert property (@(posedge clk) disable iff (!rst_n)
    (active == CODE_PLL) |-> pll_on)
    else $error("a_r10_pll_held");
endmodule

// File: rtl/sysclk_selector.sv
module sysclk_selector
  import sysclk_sel_pkg::*;
#(
  parameter int unsigned CFG_W       = 8,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned REF_BIT     = 0
) (
  input  logic               clk_ref,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_tick,
  input  logic [NUM_SRC-1:0] src_rdy,
  input  logic               req_we,
  input  logic [1:0]         req_code,
  input  logic               pll_en,
  input  logic               cfg_we,
  input  logic [CFG_W-1:0]   cfg_wdata,
  input  logic               hirc_stop,
  input  logic               hirc_start,
  output logic [1:0]         src_target,
  output logic [1:0]         src_active,
  output logic               switching,
  output logic               clk_fail,
  output logic               hirc_on,
  output logic               pll_clk_ok,
  output logic [CFG_W-1:0]   pll_cfg,
  output logic               sysclk_en
);
  localparam int unsigned IDX_RC  = 0;
  localparam int unsigned IDX_PLL = NUM_SRC - 1;

  logic [NUM_SRC-1:0] rdy_s;
  logic [NUM_SRC-1:0] usable;
  logic               pll_on;
  logic               fallback;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_sync
    rdy_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk_ref),
      .rst_n (rst_n),
      .d     (src_rdy[g]),
      .q     (rdy_s[g])
    );
  end

  always_comb begin
    usable          = rdy_s;
    usable[IDX_RC]  = rdy_s[IDX_RC] && hirc_on;
    usable[IDX_PLL] = rdy_s[IDX_PLL] && pll_on;
  end

  assign pll_clk_ok = usable[IDX_PLL];

  sysclk_switch_fsm u_fsm (
    .clk       (clk_ref),
    .rst_n     (rst_n),
    .rdy_ok    (usable),
    .tick      (src_tick),
    .req_we    (req_we),
    .req_code  (req_code),
    .active    (src_active),
    .target    (src_target),
    .switching (switching),
    .fail      (clk_fail),
    .fallback  (fallback),
    .sysclk_en (sysclk_en)
  );

  pll_rc_guard #(.CFG_W(CFG_W), .REF_BIT(REF_BIT)) u_guard (
    .clk        (clk_ref),
    .rst_n      (rst_n),
    .pll_en     (pll_en),
    .cfg_we     (cfg_we),
    .cfg_wdata  (cfg_wdata),
    .hirc_stop  (hirc_stop),
    .hirc_start (hirc_start),
    .active     (src_active),
    .target     (src_target),
    .fallback   (fallback),
    .pll_on     (pll_on),
    .pll_cfg    (pll_cfg),
    .hirc_on    (hirc_on)
  );

  // R7: gated output only follows the active source's train
  a_r7_en_follows_active: assert property (@(posedge clk_ref) disable iff (!rst_n)
    sysclk_en |-> src_tick[src_active])
    else $error("a_r7_en_follows_active");

  // R4: the PLL becomes active only while reported usable
  a_r4_pll_active_ok: assert property (@(posedge clk_ref) disable iff (!rst_n)
    ($changed(src_active) && (src_active == CODE_PLL)) |-> $past(pll_clk_ok))
    else $error("a_r4_pll_active_ok");
endmodule

// File: tb/sysclk_selector_test.sv
module sysclk_selector_test;
  localparam int CLK_PERIOD = 10;
  localparam int CFG_W      = 8;
  localparam int ID_ACT = 0, ID_TGT = 1, ID_FAIL = 2, ID_RCON = 3,
                 ID_CFG = 4, ID_PLLOK = 5, ID_SW = 6;

  logic clk_ref = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] src_tick = 3'b000;
  logic [2:0] src_rdy = 3'b001;
  logic req_we = 1'b0;
  logic [1:0] req_code = 2'b00;
  logic pll_en = 1'b0;
  logic cfg_we = 1'b0;
  logic [CFG_W-1:0] cfg_wdata = '0;
  logic hirc_stop = 1'b0;
  logic hirc_start = 1'b0;
  logic [1:0] src_target, src_active;
  logic switching, clk_fail, hirc_on, pll_clk_ok, sysclk_en;
  logic [CFG_W-1:0] pll_cfg;

  int checks = 0;
  int failures = 0;
  int viol7 = 0;
  int viol8 = 0;
  bit finished = 0;

  typedef struct {
    int          id;
    logic [31:0] exp;
    string       tag;
  } exp_t;
  exp_t sb[$];

  sysclk_selector #(.CFG_W(CFG_W)) uut (
    .clk_ref(clk_ref), .rst_n(rst_n), .src_tick(src_tick), .src_rdy(src_rdy),
    .req_we(req_we), .req_code(req_code), .pll_en(pll_en), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .hirc_stop(hirc_stop), .hirc_start(hirc_start),
    .src_target(src_target), .src_active(src_active), .switching(switching),
    .clk_fail(clk_fail), .hirc_on(hirc_on), .pll_clk_ok(pll_clk_ok),
    .pll_cfg(pll_cfg), .sysclk_en(sysclk_en)
  );

  always #(CLK_PERIOD/2) clk_ref = ~clk_ref;

  // enable trains: RC every 2nd, external every 4th (two high), PLL every 3rd
  initial begin
    int cnt;
    cnt = 0;
    forever begin
      @(posedge clk_ref);
      #1;
      cnt++;
      src_tick[0] = (cnt % 2) == 0;
      src_tick[1] = (cnt % 4) < 2;
      src_tick[2] = (cnt % 3) == 0;
    end
  end

  function automatic logic [31:0] pick(int id);
    case (id)
      ID_ACT:   return {30'd0, src_active};
      ID_TGT:   return {30'd0, src_target};
      ID_FAIL:  return {31'd0, clk_fail};
      ID_RCON:  return {31'd0, hirc_on};
      ID_CFG:   return {24'd0, pll_cfg};
      ID_PLLOK: return {31'd0, pll_clk_ok};
      default:  return {31'd0, switching};
    endcase
  endfunction

  // monitor: pops expectations and checks them; also watches the gated enable
  initial begin
    logic       prev_en;
    logic [2:0] prev_tick;
    prev_en = 1'b0;
    prev_tick = 3'b000;
    forever begin
      @(negedge clk_ref);
      if (rst_n) begin
        if (sysclk_en && !src_tick[src_active]) viol7++;
        if (sysclk_en && !prev_en && prev_tick[src_active]) viol8++;
      end
      prev_en = sysclk_en;
      prev_tick = src_tick;
      if (sb.size() > 0) begin
        exp_t it;
        logic [31:0] act;
        it = sb.pop_front();
        act = pick(it.id);
        checks++;
        if (act !== it.exp) begin
          failures++;
          $display("FAIL %s actual=%0h expected=%0h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic expect_val(int id, logic [31:0] exp, string tag);
    @(posedge clk_ref);
    #2;
    sb.push_back('{id: id, exp: exp, tag: tag});
    wait (sb.size() == 0);
  endtask

  task automatic settle(int n);
    repeat (n) @(posedge clk_ref);
  endtask

  task automatic request(logic [1:0] code);
    @(posedge clk_ref); #1; req_we = 1'b1; req_code = code;
    @(posedge clk_ref); #1; req_we = 1'b0;
  endtask

  task automatic write_cfg(logic [CFG_W-1:0] v);
    @(posedge clk_ref); #1; cfg_we = 1'b1; cfg_wdata = v;
    @(posedge clk_ref); #1; cfg_we = 1'b0;
  endtask

  task automatic pulse_stop();
    @(posedge clk_ref); #1; hirc_stop = 1'b1;
    @(posedge clk_ref); #1; hirc_stop = 1'b0;
  endtask

  task automatic pulse_start();
    @(posedge clk_ref); #1; hirc_start = 1'b1;
    @(posedge clk_ref); #1; hirc_start = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk_ref);
    failures++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    settle(3);
    #1 rst_n = 1'b1;
    settle(4);
    // R1 reset state
    expect_val(ID_ACT, 0, "R1 active after reset");
    expect_val(ID_TGT, 0, "R1 target after reset");
    expect_val(ID_FAIL, 0, "R1 fail after reset");
    expect_val(ID_RCON, 1, "R1 rc on after reset");
    expect_val(ID_CFG, 0, "R1 cfg after reset");
    expect_val(ID_PLLOK, 0, "R1 pll ok after reset");
    // R2 reserved code
    request(2'b11);
    settle(3);
    expect_val(ID_TGT, 0, "R2 reserved code ignored");
    // R3 wait for external ready
    request(2'b01);
    settle(20);
    expect_val(ID_TGT, 1, "R2 target loaded");
    expect_val(ID_ACT, 0, "R3 stays on rc while target not ready");
    expect_val(ID_SW, 1, "R3 switching while waiting");
    #1 src_rdy[1] = 1'b1;
    settle(20);
    expect_val(ID_ACT, 1, "R3 switched to external");
    expect_val(ID_SW, 0, "R3 handover done");
    // R5 cfg write with PLL off (bit0=0: RC reference)
    write_cfg(8'h5A);
    settle(2);
    expect_val(ID_CFG, 32'h5A, "R5 cfg written while pll off");
    // R4 PLL enabled but not stable
    #1 pll_en = 1'b1;
    settle(4);
    request(2'b10);
    settle(20);
    expect_val(ID_PLLOK, 0, "R4 pll not ok without ready");
    expect_val(ID_ACT, 1, "R4 pll not selected without ready");
    write_cfg(8'hC3);
    settle(2);
    expect_val(ID_CFG, 32'h5A, "R5 cfg write dropped while pll on");
    #1 src_rdy[2] = 1'b1;
    settle(20);
    expect_val(ID_PLLOK, 1, "R4 pll ok");
    expect_val(ID_ACT, 2, "R4 switched to pll");
    // R6 RC feeds the active PLL
    pulse_stop();
    settle(2);
    expect_val(ID_RCON, 1, "R6 stop ignored while rc feeds pll");
    // R10 PLL disable while active
    #1 pll_en = 1'b0;
    settle(6);
    expect_val(ID_PLLOK, 1, "R10 pll held while active");
    // R9 PLL loses ready
    #1 src_rdy[2] = 1'b0;
    settle(10);
    expect_val(ID_ACT, 0, "R9 fallback to rc");
    expect_val(ID_TGT, 0, "R9 target reset to rc");
    expect_val(ID_FAIL, 1, "R9 fail set");
    expect_val(ID_PLLOK, 0, "R10 pll stops once unused");
    write_cfg(8'h33);
    settle(2);
    expect_val(ID_CFG, 32'h33, "R5 cfg written after pll stopped");
    #1 src_rdy[2] = 1'b1;
    request(2'b01);
    settle(20);
    expect_val(ID_ACT, 1, "R3 back on external");
    expect_val(ID_FAIL, 1, "R9 fail sticky");
    // R6 stop honoured when rc unused
    pulse_stop();
    settle(2);
    expect_val(ID_RCON, 0, "R6 rc stopped when unused");
    request(2'b00);
    settle(20);
    expect_val(ID_ACT, 1, "R3 rc not usable while stopped");
    expect_val(ID_RCON, 0, "R6 stop kept while rc only requested");
    pulse_start();
    settle(20);
    expect_val(ID_RCON, 1, "R6 rc restarted");
    expect_val(ID_ACT, 0, "R3 switched to rc after restart");
    // R7 / R8 gated enable behaviour across all handovers
    checks++;
    if (viol7 != 0) begin
      failures++;
      $display("FAIL R7 enable outside active train actual=%0d expected=0", viol7);
    end
    checks++;
    if (viol8 != 0) begin
      failures++;
      $display("FAIL R8 partial first pulse actual=%0d expected=0", viol8);
    end
    finish_run();
  end
endmodule